// File: doc/BRIEF.md
# Banked Sound CPU Address Decoder

This block sits between an 8-bit sound processor with a 64 KB address space and the parts around it. It decodes every bus cycle into a chip select for program RAM, for a two-port music synthesizer and for a four-register parallel interface adapter. Writes to two address ranges become one-cycle strobes that clock a speech codec. Decoding is deliberately incomplete, so each part answers across a wide mirror of its base address.

The upper half of the address space is a 32 KB window onto banked program ROM. A 4-bit bank register is loaded by a write to its own range. Its low two bits pick one of three ROM devices, or none. Its high two bits become physical address lines 15 and 16. The block returns the read data of whichever part is selected. It returns 0xFF on a floating bus. A board-level hold input forces the bank back to zero.

Top module: `snd_addr_decoder`

## Requirements
- R1: A bus cycle with cpu_addr[15:13] = 000 asserts ram_cs, with ram_addr = cpu_addr[10:0], so 2 KB of RAM mirrors four times across 0x0000-0x1FFF; a read returns ram_rdata.
- R2: A bus cycle with cpu_addr[15:13] = 001 asserts synth_cs, with synth_port = cpu_addr[0] (0 = register port, 1 = status/data port); a read returns synth_rdata.
- R3: A bus cycle with cpu_addr[15:13] = 010 asserts pia_cs, with pia_reg = cpu_addr[1:0]; a read returns pia_rdata.
- R4: A write with cpu_addr[15:11] = 01100 raises codec_lo_stb for that cycle, and codec_bit carries cpu_wdata[0].
- R5: A write with cpu_addr[15:11] = 01101 raises codec_hi_stb for that cycle, whatever the data; at most one chip select or strobe is active in any cycle.
- R6: A write with cpu_addr[15:11] = 01111 loads cpu_wdata[3:0] into the bank register at the clock edge; cpu_wdata[7:4] is ignored.
- R7: A read with cpu_addr[15] = 1 and bank[1:0] = n < 3 asserts rom_cs bit n only, and the cycle returns rom_rdata.
- R8: rom_phys_addr = 0x20000*bank[1:0] + 0x8000*bank[3:2] + cpu_addr[14:0], i.e. {bank[1:0], bank[3:2], cpu_addr[14:0]}.
- R9: With bank[1:0] = 3, a read in the ROM window asserts no rom_cs bit and returns 0xFF.
- R10: board_hold high makes the bank 0 at the next edge, and it wins over a bank write in the same cycle.
- R11: Writes to the ROM window select nothing and leave the bank unchanged; reads of the codec, gap (01110) or bank ranges raise no strobe and return 0xFF, as does an idle bus.
- R12: After rst_n is released, the bank register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| board_hold | input | 1 | Board hold; forces the bank to 0 |
| cpu_valid | input | 1 | A bus cycle is in progress |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| ram_rdata | input | 8 | Program RAM read data |
| synth_rdata | input | 8 | Synthesizer read data |
| pia_rdata | input | 8 | Interface adapter read data |
| rom_rdata | input | 8 | Selected ROM device read data |
| ram_cs | output | 1 | Program RAM select |
| ram_addr | output | 11 | Program RAM address |
| synth_cs | output | 1 | Synthesizer select |
| synth_port | output | 1 | Synthesizer port select |
| pia_cs | output | 1 | Interface adapter select |
| pia_reg | output | 2 | Interface adapter register |
| codec_lo_stb | output | 1 | Codec clock-low and digit-latch strobe |
| codec_bit | output | 1 | Codec digit bit |
| codec_hi_stb | output | 1 | Codec clock-high strobe |
| rom_cs | output | 3 | One-hot ROM device select |
| rom_phys_addr | output | 19 | Physical ROM address |

## Verification
The bank register has two writers that can act in the same cycle: a CPU bank write and the board hold. The bench drives a bank write of a non-zero value while holding board_hold high. It then reads the ROM window and expects device 0 at physical offset 0, which shows that the hold took priority. A second case loads a bank first and then applies the hold alone. This separates "hold clears" from "write was lost".

// File: rtl/snd_dec_pkg.sv
package snd_dec_pkg;

    localparam int BANK_BITS = 4;

    typedef enum logic [2:0] {
        RG_RAM,
        RG_SYNTH,
        RG_PIA,
        RG_CODEC_LO,
        RG_CODEC_HI,
        RG_GAP,
        RG_BANK,
        RG_ROM
    } region_e;

    typedef struct packed {
        logic [BANK_BITS-1:0] bank;
    } dec_state_t;

endpackage

// File: rtl/snd_region_decode.sv
// Classifies the top five address bits into a region; lower bits are
// never looked at here, which produces the mirrors.
module snd_region_decode
    import snd_dec_pkg::*;
(
    input  logic [4:0] addr_top,
    output region_e    region
);
    always_comb begin
        if (addr_top[4]) begin
            region = RG_ROM;
        end else begin
            unique case (addr_top[3:2])
                2'b00: region = RG_RAM;
                2'b01: region = RG_SYNTH;
                2'b10: region = RG_PIA;
                default: begin
                    unique case (addr_top[1:0])
                        2'b00:   region = RG_CODEC_LO;
                        2'b01:   region = RG_CODEC_HI;
                        2'b10:   region = RG_GAP;
                        default: region = RG_BANK;
                    endcase
                end
            endcase
        end
    end
endmodule

// File: rtl/snd_bank_map.sv
// Turns the bank value plus window offset into a device select and a
// physical address: device field on top, then the high bank bits.
module snd_bank_map #(
    parameter int BANK_W  = 4,
    parameter int WIN_W   = 15,
    parameter int DEV_CNT = 3,
    localparam int SEL_W  = 2,
    localparam int HI_W   = BANK_W - SEL_W,
    localparam int PHYS_W = WIN_W + BANK_W
) (
    input  logic              en,
    input  logic [BANK_W-1:0] bank,
    input  logic [WIN_W-1:0]  win_addr,
    output logic [DEV_CNT-1:0] dev_cs,
    output logic [PHYS_W-1:0] phys_addr
);
    logic [SEL_W-1:0] dev_sel;
    logic [HI_W-1:0]  hi_bits;

    assign dev_sel   = bank[SEL_W-1:0];
    assign hi_bits   = bank[BANK_W-1:SEL_W];
    assign phys_addr = {dev_sel, hi_bits, win_addr};

    for (genvar g = 0; g < DEV_CNT; g++) begin : g_dev
        assign dev_cs[g] = en && (dev_sel == SEL_W'(g));
    end
endmodule

// File: rtl/snd_read_mux.sv
// Returns the selected part's read data, or the floating-bus value.
module snd_read_mux
    import snd_dec_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              rd_en,
    input  region_e           region,
    input  logic              rom_hit,
    input  logic [DATA_W-1:0] ram_rdata,
    input  logic [DATA_W-1:0] synth_rdata,
    input  logic [DATA_W-1:0] pia_rdata,
    input  logic [DATA_W-1:0] rom_rdata,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [DATA_W-1:0] FLOAT = '1;

    always_comb begin
        rdata = FLOAT;
        if (rd_en) begin
            unique case (region)
                RG_RAM:   rdata = ram_rdata;
                RG_SYNTH: rdata = synth_rdata;
                RG_PIA:   rdata = pia_rdata;
                RG_ROM:   rdata = rom_hit ? rom_rdata : FLOAT;
                default:  rdata = FLOAT;
            endcase
        end
    end
endmodule

// File: rtl/snd_addr_decoder.sv
module snd_addr_decoder
    import snd_dec_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int DEV_CNT = 3,
    parameter int RAM_AW  = 11,
    localparam int BANK_W = BANK_BITS,
    localparam int WIN_W  = ADDR_W - 1,
    localparam int PHYS_W = WIN_W + BANK_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               board_hold,
    input  logic               cpu_valid,
    input  logic               cpu_rw,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [DATA_W-1:0]  cpu_wdata,
    output logic [DATA_W-1:0]  cpu_rdata,
    input  logic [DATA_W-1:0]  ram_rdata,
    input  logic [DATA_W-1:0]  synth_rdata,
    input  logic [DATA_W-1:0]  pia_rdata,
    input  logic [DATA_W-1:0]  rom_rdata,
    output logic               ram_cs,
    output logic [RAM_AW-1:0]  ram_addr,
    output logic               synth_cs,
    output logic               synth_port,
    output logic               pia_cs,
    output logic [1:0]         pia_reg,
    output logic               codec_lo_stb,
    output logic               codec_bit,
    output logic               codec_hi_stb,
    output logic [DEV_CNT-1:0] rom_cs,
    output logic [PHYS_W-1:0]  rom_phys_addr
);
    region_e     region;
    dec_state_t  state_d, state_q;
    logic        rd_cyc, wr_cyc, bank_wr, rom_rd;
    logic [BANK_W-1:0] bank_q;
    logic        unused_wdata;

    assign unused_wdata = &{1'b0, cpu_wdata[DATA_W-1:BANK_W]};

    snd_region_decode u_region (
        .addr_top (cpu_addr[ADDR_W-1 -: 5]),
        .region   (region)
    );

    assign rd_cyc  = cpu_valid &&  cpu_rw;
    assign wr_cyc  = cpu_valid && !cpu_rw;
    assign bank_wr = wr_cyc && (region == RG_BANK);
    assign rom_rd  = rd_cyc && (region == RG_ROM);
    assign bank_q  = state_q.bank;

    // next-state process: hold has the last word over a bank write
    always_comb begin
        state_d = state_q;
        if (bank_wr) begin
            state_d.bank = cpu_wdata[BANK_W-1:0];
        end
        if (board_hold) begin
            state_d.bank = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign ram_cs       = cpu_valid && (region == RG_RAM);
    assign ram_addr     = cpu_addr[RAM_AW-1:0];
    assign synth_cs     = cpu_valid && (region == RG_SYNTH);
    assign synth_port   = cpu_addr[0];
    assign pia_cs       = cpu_valid && (region == RG_PIA);
    assign pia_reg      = cpu_addr[1:0];
    assign codec_lo_stb = wr_cyc && (region == RG_CODEC_LO);
    assign codec_bit    = codec_lo_stb && cpu_wdata[0];
    assign codec_hi_stb = wr_cyc && (region == RG_CODEC_HI);

    snd_bank_map #(
        .BANK_W  (BANK_W),
        .WIN_W   (WIN_W),
        .DEV_CNT (DEV_CNT)
    ) u_bank_map (
        .en        (rom_rd),
        .bank      (state_q.bank),
        .win_addr  (cpu_addr[WIN_W-1:0]),
        .dev_cs    (rom_cs),
        .phys_addr (rom_phys_addr)
    );

    snd_read_mux #(
        .DATA_W (DATA_W)
    ) u_rmux (
        .rd_en       (rd_cyc),
        .region      (region),
        .rom_hit     (|rom_cs),
        .ram_rdata   (ram_rdata),
        .synth_rdata (synth_rdata),
        .pia_rdata   (pia_rdata),
        .rom_rdata   (rom_rdata),
        .rdata       (cpu_rdata)
    );
endmodule

// File: rtl/snd_dec_checker.sv
module snd_dec_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        board_hold,
    input logic        cpu_valid,
    input logic        cpu_rw,
    input logic [15:0] cpu_addr,
    input logic [7:0]  cpu_wdata,
    input logic [7:0]  cpu_rdata,
    input logic [3:0]  bank_q,
    input logic        ram_cs,
    input logic        synth_cs,
    input logic        pia_cs,
    input logic        codec_lo_stb,
    input logic        codec_hi_stb,
    input logic [2:0]  rom_cs
);
    // R6: bank write lands next cycle
    a_r6_bank_load: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && !cpu_rw && cpu_addr[15:11] == 5'b01111 && !board_hold)
        |=> bank_q == $past(cpu_wdata[3:0]));

    // R10: hold clears the bank
    a_r10_hold_clears: assert property (@(posedge clk) disable iff (!rst_n)
        board_hold |=> bank_q == 4'd0);

    // R5: never two selects at once
    a_r5_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_cs, synth_cs, pia_cs, codec_lo_stb, codec_hi_stb, |rom_cs}));

    // R7: device selects are one-hot
    a_r7_rom_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rom_cs));

    // R9: empty device slot floats the bus
    a_r9_no_device: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && cpu_rw && cpu_addr[15] && bank_q[1:0] == 2'd3)
        |-> (rom_cs == 3'b000 && cpu_rdata == 8'hFF));

    // R11: ROM-window writes change nothing
    a_r11_rom_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && !cpu_rw && cpu_addr[15] && !board_hold)
        |=> $stable(bank_q));
endmodule

bind snd_addr_decoder snd_dec_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .board_hold   (board_hold),
    .cpu_valid    (cpu_valid),
    .cpu_rw       (cpu_rw),
    .cpu_addr     (cpu_addr),
    .cpu_wdata    (cpu_wdata),
    .cpu_rdata    (cpu_rdata),
    .bank_q       (bank_q),
    .ram_cs       (ram_cs),
    .synth_cs     (synth_cs),
    .pia_cs       (pia_cs),
    .codec_lo_stb (codec_lo_stb),
    .codec_hi_stb (codec_hi_stb),
    .rom_cs       (rom_cs)
);

// File: tb/tb_snd_addr_decoder.sv
module tb_snd_addr_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        board_hold = 1'b0;
    logic        cpu_valid = 1'b0;
    logic        cpu_rw = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic [7:0]  ram_rdata = 8'h11, synth_rdata = 8'h22, pia_rdata = 8'h33, rom_rdata = 8'hC3;
    logic        ram_cs, synth_cs, synth_port, pia_cs, codec_lo_stb, codec_bit, codec_hi_stb;
    logic [10:0] ram_addr;
    logic [1:0]  pia_reg;
    logic [2:0]  rom_cs;
    logic [18:0] rom_phys_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    snd_addr_decoder dut (
        .clk(clk), .rst_n(rst_n), .board_hold(board_hold), .cpu_valid(cpu_valid),
        .cpu_rw(cpu_rw), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .ram_rdata(ram_rdata), .synth_rdata(synth_rdata), .pia_rdata(pia_rdata),
        .rom_rdata(rom_rdata), .ram_cs(ram_cs), .ram_addr(ram_addr), .synth_cs(synth_cs),
        .synth_port(synth_port), .pia_cs(pia_cs), .pia_reg(pia_reg),
        .codec_lo_stb(codec_lo_stb), .codec_bit(codec_bit), .codec_hi_stb(codec_hi_stb),
        .rom_cs(rom_cs), .rom_phys_addr(rom_phys_addr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // select vector: {ram, synth, pia, lo, hi, rom_cs[2:0]}
    function automatic logic [31:0] sels();
        return {24'd0, ram_cs, synth_cs, pia_cs, codec_lo_stb, codec_hi_stb, rom_cs};
    endfunction

    // drive a cycle at the falling edge and settle before sampling
    task automatic drive(input logic rw, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_valid = 1'b1; cpu_rw = rw; cpu_addr = a; cpu_wdata = d;
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        cpu_valid = 1'b0; cpu_rw = 1'b1; board_hold = 1'b0;
        #1;
    endtask

    task automatic bank_write(input logic [7:0] d);
        drive(1'b0, 16'h7800, d);
        idle();
    endtask

    // read in the window, compare against bank-derived expectations
    task automatic rom_probe(input string req, input logic [15:0] a, input logic [3:0] b);
        logic [31:0] exp_phys;
        drive(1'b1, a, 8'h00);
        exp_phys = 32'h20000 * b[1:0] + 32'h8000 * b[3:2] + {17'd0, a[14:0]};
        chk({req, " phys"}, {13'd0, rom_phys_addr}, exp_phys);
        if (b[1:0] == 2'd3) begin
            chk({req, " R9 no cs"}, {29'd0, rom_cs}, 32'd0);
            chk({req, " R9 float"}, {24'd0, cpu_rdata}, 32'hFF);
        end else begin
            chk({req, " R7 cs"}, {29'd0, rom_cs}, 32'd1 << b[1:0]);
            chk({req, " R7 data"}, {24'd0, cpu_rdata}, {24'd0, rom_rdata});
        end
        idle();
    endtask

    task automatic t_reset();
        chk("R12 idle float", {24'd0, cpu_rdata}, 32'hFF);
        chk("R12 no selects", sels(), 32'd0);
        rom_probe("R12 bank0", 16'h8000, 4'h0);
    endtask

    task automatic t_ram();
        drive(1'b1, 16'h0123, 8'h00);
        chk("R1 cs", sels(), 32'h80);
        chk("R1 data", {24'd0, cpu_rdata}, 32'h11);
        drive(1'b0, 16'h1D55, 8'hAA);
        chk("R1 mirror cs", sels(), 32'h80);
        chk("R1 mirror addr", {21'd0, ram_addr}, 32'h555);
        idle();
    endtask

    task automatic t_synth();
        drive(1'b0, 16'h2000, 8'h01);
        chk("R2 reg port", {30'd0, synth_cs, synth_port}, 32'h2);
        drive(1'b1, 16'h3FFF, 8'h00);
        chk("R2 mirror status", {30'd0, synth_cs, synth_port}, 32'h3);
        chk("R2 data", {24'd0, cpu_rdata}, 32'h22);
        idle();
    endtask

    task automatic t_pia();
        for (int r = 0; r < 4; r++) begin
            drive(1'b1, 16'h5AF0 | 16'(r), 8'h00);
            chk("R3 cs", sels(), 32'h20);
            chk("R3 reg", {30'd0, pia_reg}, 32'(r));
        end
        chk("R3 data", {24'd0, cpu_rdata}, 32'h33);
        idle();
    endtask

    task automatic t_codec();
        drive(1'b0, 16'h6000, 8'hFF);
        chk("R4 lo stb", sels(), 32'h10);
        chk("R4 bit1", {31'd0, codec_bit}, 32'd1);
        drive(1'b0, 16'h67FE, 8'hFE);
        chk("R4 bit0", {31'd0, codec_bit}, 32'd0);
        drive(1'b0, 16'h6ABC, 8'h5A);
        chk("R5 hi stb", sels(), 32'h08);
        idle();
    endtask

    task automatic t_banks();
        for (int b = 0; b < 16; b++) begin
            bank_write(8'hF0 | 8'(b));   // R6: upper data bits ignored
            rom_probe("R6 R8 bank", 16'h8000 | 16'(b * 16'h0731), 4'(b));
        end
    endtask

    task automatic t_hold();
        bank_write(8'h05);
        @(negedge clk);
        board_hold = 1'b1;
        idle();
        rom_probe("R10 hold alone", 16'hC000, 4'h0);
        // simultaneous bank write and hold: hold must win
        @(negedge clk);
        cpu_valid = 1'b1; cpu_rw = 1'b0; cpu_addr = 16'h7FFF; cpu_wdata = 8'h06;
        board_hold = 1'b1;
        idle();
        rom_probe("R10 hold vs write", 16'hFFFF, 4'h0);
    endtask

    task automatic t_ignored();
        bank_write(8'h09);
        drive(1'b0, 16'h9234, 8'h03);
        chk("R11 rom write no cs", sels(), 32'd0);
        idle();
        rom_probe("R11 bank kept", 16'h9234, 4'h9);
        drive(1'b1, 16'h6000, 8'h00);
        chk("R11 rd lo none", sels(), 32'd0);
        chk("R11 rd lo float", {24'd0, cpu_rdata}, 32'hFF);
        drive(1'b1, 16'h6800, 8'h00);
        chk("R11 rd hi none", sels(), 32'd0);
        drive(1'b1, 16'h7800, 8'h00);
        chk("R11 rd bank float", {24'd0, cpu_rdata}, 32'hFF);
        drive(1'b0, 16'h7000, 8'h0F);
        chk("R11 gap write none", sels(), 32'd0);
        idle();
        rom_probe("R11 gap no load", 16'h8001, 4'h9);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_ram();
        t_synth();
        t_pia();
        t_codec();
        t_banks();
        t_hold();
        t_ignored();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog (all requirements): actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule